// File: doc/BRIEF.md
# Expanded Data RAM Access Router

This block sits on the external-data port of a small 8-bit CPU. It decides, for every external-data read or write, whether the access goes to a 768-byte on-chip RAM or out to an external memory bus. Addresses 0x0000 to 0x02FF are served on chip while the on-chip RAM is enabled. Every higher address, and every address once the RAM is disabled, drives the active-low external read or write strobes. Read data from either target reaches the CPU one clock after the read request.

A system control register sits at special-function address 0xBF. Its bits:

- bit 1 (RAM enable) selects whether the on-chip RAM is used.
- bit 0 (ALE inhibit) silences the idle, free-running address-latch-enable pulse, which runs at one sixth of the clock.
- bit 2 (ISP enable) is driven out to the flash programming logic.
- bit 7 is a sticky flag that marks a reset caused by the watchdog.

An external-bus access still produces an ALE pulse even while the inhibit bit is set.

Top module: `xdata_router`

## Requirements
- R1: After power-on reset (rst_n low) the control register reads 0x02: RAM enable (bit 1) is 1, and ALE inhibit (bit 0), ISP enable (bit 2) and the watchdog flag (bit 7) are 0. The isp_en output is 0.
- R2: With RAM enable set, a write to an address from 0x0000 through 0x02FF stores the byte in on-chip RAM. A read of such an address returns the byte on x_rdata in the cycle after x_rd. During both, ext_rd_n and ext_wr_n stay high.
- R3: An access to an address above 0x02FF asserts ext_wr_n (write) or ext_rd_n (read) low in the same cycle, with ext_addr equal to x_addr. It leaves the on-chip RAM contents unchanged.
- R4: With RAM enable cleared, every access, including those in 0x0000 to 0x02FF, goes to the external strobes. On-chip contents are kept and are readable again once the bit is set.
- R5: The control register is written and read only at special-function address 0xBF. Writes to other addresses change nothing, and reads of other addresses return 0.
- R6: Bits 6 down to 3 of the control register always read 0, whatever was written to them.
- R7: With ALE inhibit clear and no external access, ale is high for one cycle in every 6 (ALE_DIV).
- R8: With ALE inhibit set, the idle ale pulse is suppressed. The first cycle of an external-bus access still drives ale high.
- R9: A watchdog reset (wdt_rst high for a cycle) sets bit 7 and returns bits 2..0 to their reset values. Bit 7 is cleared only by power-on reset or by software writing 0 to it.
- R10: An external read returns, on x_rdata in the cycle after x_rd, the ext_rdata value present during the read cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| wdt_rst | input | 1 | Watchdog reset event, synchronous, one cycle |
| x_addr | input | 16 | External-data address from the CPU |
| x_rd | input | 1 | External-data read request |
| x_wr | input | 1 | External-data write request |
| x_wdata | input | 8 | External-data write byte |
| x_rdata | output | 8 | Read byte, valid the cycle after x_rd |
| sfr_addr | input | 8 | Special-function address |
| sfr_wr | input | 1 | Special-function write strobe |
| sfr_wdata | input | 8 | Special-function write byte |
| sfr_rdata | output | 8 | Control register value when sfr_addr is 0xBF, else 0 |
| ext_addr | output | 16 | External bus address |
| ext_wdata | output | 8 | External bus write byte |
| ext_rdata | input | 8 | External bus read byte |
| ext_rd_n | output | 1 | External read strobe, active low |
| ext_wr_n | output | 1 | External write strobe, active low |
| ale | output | 1 | Address latch enable |
| isp_en | output | 1 | ISP enable, control register bit 2 |

## Verification
The routing is exercised with addresses at both edges of the internal window (0x0000, 0x02FF) and just past it (0x0300, 0xFFFF), so that an off-by-one in the boundary compare shows up. Writing above the window and then reading low internal addresses separates a correct route from one that aliases into the RAM. The same low address is also accessed with the RAM disabled and then re-enabled, which shows that the enable bit steers the access and does not destroy the contents. ALE is counted over a fixed window with the inhibit bit clear and set, and sampled inside an external access. This tells idle-pulse suppression apart from suppression of the bus-cycle latch pulse.

// File: rtl/xr_pkg.sv
package xr_pkg;
   localparam logic [7:0] CTRL_SFR_ADDR = 8'hBF;

   // control register contents; bit positions are fixed in xr_ctrl
   typedef struct packed {
      logic wdt_flag;   // bit 7
      logic isp_on;     // bit 2
      logic ram_on;     // bit 1
      logic ale_off;    // bit 0
   } ctrl_t;

   localparam ctrl_t CTRL_RESET = '{wdt_flag: 1'b0, isp_on: 1'b0, ram_on: 1'b1, ale_off: 1'b0};
endpackage

// File: rtl/xr_ctrl.sv
module xr_ctrl
   import xr_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wdt_rst,
   input  logic [7:0] sfr_addr,
   input  logic       sfr_wr,
   input  logic [7:0] sfr_wdata,
   output logic [7:0] sfr_rdata,
   output ctrl_t      ctrl
);
   ctrl_t ctrl_q;
   logic  hit;

   assign hit = (sfr_addr == CTRL_SFR_ADDR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= CTRL_RESET;
      end else if (wdt_rst) begin
         ctrl_q          <= CTRL_RESET;
         ctrl_q.wdt_flag <= 1'b1;
      end else if (sfr_wr && hit) begin
         ctrl_q.wdt_flag <= sfr_wdata[7];
         ctrl_q.isp_on   <= sfr_wdata[2];
         ctrl_q.ram_on   <= sfr_wdata[1];
         ctrl_q.ale_off  <= sfr_wdata[0];
      end
   end

   // reserved bits 6..3 read as zero
   assign sfr_rdata = hit ? {ctrl_q.wdt_flag, 4'b0000, ctrl_q.isp_on,
                             ctrl_q.ram_on, ctrl_q.ale_off} : 8'h00;
   assign ctrl = ctrl_q;

   // R9
   wdt_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_rst |=> (ctrl_q.wdt_flag && ctrl_q.ram_on && !ctrl_q.isp_on && !ctrl_q.ale_off));

   // R5
   foreign_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!hit && !wdt_rst) |=> $stable(ctrl_q));
endmodule

// File: rtl/xr_decode.sv
module xr_decode #(
   parameter int ADDR_W    = 16,
   parameter int RAM_DEPTH = 768
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              rd,
   input  logic              wr,
   input  logic              ram_on,
   output logic              ram_we,
   output logic              ram_re,
   output logic              ext_rd,
   output logic              ext_wr
);
   localparam logic [ADDR_W-1:0] RAM_LAST = ADDR_W'(RAM_DEPTH - 1);

   logic in_window;
   logic to_ram;

   assign in_window = (addr <= RAM_LAST);
   assign to_ram    = in_window && ram_on;

   always_comb begin
      ram_we = 1'b0;
      ram_re = 1'b0;
      ext_rd = 1'b0;
      ext_wr = 1'b0;
      if (to_ram) begin
         ram_we = wr;
         ram_re = rd;
      end else begin
         ext_wr = wr;
         ext_rd = rd;
      end
   end
endmodule

// File: rtl/xr_ram.sv
module xr_ram #(
   parameter int DEPTH  = 768,
   parameter int DATA_W = 8,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              we,
   input  logic              re,
   input  logic [IDX_W-1:0]  idx,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] mem [DEPTH];
   logic [DATA_W-1:0] rdata_q;

   always_ff @(posedge clk) begin
      if (we) mem[idx] <= wdata;
      if (re) rdata_q <= mem[idx];
   end

   assign rdata = rdata_q;
endmodule

// File: rtl/xr_ale_gen.sv
module xr_ale_gen #(
   parameter int DIV = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic inhibit,
   input  logic bus_start,
   output logic ale
);
   localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
   localparam logic [CW-1:0] LAST = CW'(DIV - 1);

   generate
      if (DIV < 2) begin : g_bad_div
         $error("xr_ale_gen: DIV must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt_q;
   logic          tick;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (cnt_q == LAST) cnt_q <= '0;
      else                    cnt_q <= cnt_q + 1'b1;
   end

   assign tick = (cnt_q == '0);
   assign ale  = (tick && !inhibit) || bus_start;

   // R7
   ale_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
endmodule

// File: rtl/xdata_router.sv
module xdata_router
   import xr_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 8,
   parameter int RAM_DEPTH = 768,
   parameter int ALE_DIV   = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wdt_rst,
   input  logic [ADDR_W-1:0] x_addr,
   input  logic              x_rd,
   input  logic              x_wr,
   input  logic [DATA_W-1:0] x_wdata,
   output logic [DATA_W-1:0] x_rdata,
   input  logic [7:0]        sfr_addr,
   input  logic              sfr_wr,
   input  logic [7:0]        sfr_wdata,
   output logic [7:0]        sfr_rdata,
   output logic [ADDR_W-1:0] ext_addr,
   output logic [DATA_W-1:0] ext_wdata,
   input  logic [DATA_W-1:0] ext_rdata,
   output logic              ext_rd_n,
   output logic              ext_wr_n,
   output logic              ale,
   output logic              isp_en
);
   localparam int IDX_W = $clog2(RAM_DEPTH);
   localparam logic [ADDR_W-1:0] RAM_LAST = ADDR_W'(RAM_DEPTH - 1);

   generate
      if (RAM_DEPTH > (2 ** ADDR_W)) begin : g_bad_depth
         $error("xdata_router: RAM_DEPTH exceeds address space");
      end
      if (IDX_W > ADDR_W) begin : g_bad_idx
         $error("xdata_router: RAM index wider than address");
      end
   endgenerate

   ctrl_t             ctrl;
   logic              ram_we, ram_re, ext_rd, ext_wr;
   logic              ext_act_q, bus_start;
   logic              src_ext_q;
   logic [DATA_W-1:0] ext_cap_q;
   logic [DATA_W-1:0] ram_rdata;

   xr_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .wdt_rst   (wdt_rst),
      .sfr_addr  (sfr_addr),
      .sfr_wr    (sfr_wr),
      .sfr_wdata (sfr_wdata),
      .sfr_rdata (sfr_rdata),
      .ctrl      (ctrl)
   );

   xr_decode #(.ADDR_W(ADDR_W), .RAM_DEPTH(RAM_DEPTH)) u_dec (
      .addr   (x_addr),
      .rd     (x_rd),
      .wr     (x_wr),
      .ram_on (ctrl.ram_on),
      .ram_we (ram_we),
      .ram_re (ram_re),
      .ext_rd (ext_rd),
      .ext_wr (ext_wr)
   );

   xr_ram #(.DEPTH(RAM_DEPTH), .DATA_W(DATA_W)) u_ram (
      .clk   (clk),
      .we    (ram_we),
      .re    (ram_re),
      .idx   (x_addr[IDX_W-1:0]),
      .wdata (x_wdata),
      .rdata (ram_rdata)
   );

   // external side: address and data pass straight through
   assign ext_addr  = x_addr;
   assign ext_wdata = x_wdata;
   assign ext_rd_n  = !ext_rd;
   assign ext_wr_n  = !ext_wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ext_act_q <= 1'b0;
         src_ext_q <= 1'b0;
         ext_cap_q <= '0;
      end else begin
         ext_act_q <= ext_rd || ext_wr;
         if (x_rd) src_ext_q <= ext_rd;
         if (ext_rd) ext_cap_q <= ext_rdata;
      end
   end

   assign bus_start = (ext_rd || ext_wr) && !ext_act_q;
   assign x_rdata   = src_ext_q ? ext_cap_q : ram_rdata;
   assign isp_en    = ctrl.isp_on;

   xr_ale_gen #(.DIV(ALE_DIV)) u_ale (
      .clk       (clk),
      .rst_n     (rst_n),
      .inhibit   (ctrl.ale_off),
      .bus_start (bus_start),
      .ale       (ale)
   );

   // R2
   int_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_we || ram_re) |-> (ext_rd_n && ext_wr_n));

   // R3
   high_addr_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (x_addr > RAM_LAST) |-> (!ram_we && !ram_re));

   // R4
   ram_off_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl.ram_on && x_wr) |-> (!ram_we && !ext_wr_n));

   // R8
   ale_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl.ale_off && ext_rd_n && ext_wr_n) |-> !ale);
endmodule

// File: tb/xdata_router_tb_top.sv
module xdata_router_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wdt_rst = 1'b0;
   logic [15:0] x_addr = '0;
   logic        x_rd = 1'b0, x_wr = 1'b0;
   logic [7:0]  x_wdata = '0;
   logic [7:0]  x_rdata;
   logic [7:0]  sfr_addr = '0;
   logic        sfr_wr = 1'b0;
   logic [7:0]  sfr_wdata = '0;
   logic [7:0]  sfr_rdata;
   logic [15:0] ext_addr;
   logic [7:0]  ext_wdata, ext_rdata;
   logic        ext_rd_n, ext_wr_n, ale, isp_en;

   int vectors = 0;
   int fails   = 0;

   always #10 clk = ~clk;   // 50 MHz

   // external memory model: data derived from the address
   assign ext_rdata = ext_addr[7:0] ^ 8'h5A;

   xdata_router dut_i (
      .clk(clk), .rst_n(rst_n), .wdt_rst(wdt_rst),
      .x_addr(x_addr), .x_rd(x_rd), .x_wr(x_wr), .x_wdata(x_wdata), .x_rdata(x_rdata),
      .sfr_addr(sfr_addr), .sfr_wr(sfr_wr), .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata),
      .ext_addr(ext_addr), .ext_wdata(ext_wdata), .ext_rdata(ext_rdata),
      .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n), .ale(ale), .isp_en(isp_en)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
   endtask

   task automatic sfr_write(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      sfr_addr = a; sfr_wdata = d; sfr_wr = 1'b1;
      @(negedge clk);
      sfr_wr = 1'b0;
   endtask

   task automatic sfr_read(input logic [7:0] a, output logic [7:0] d);
      @(negedge clk);
      sfr_addr = a;
      #1 d = sfr_rdata;
   endtask

   task automatic xwr(input logic [15:0] a, input logic [7:0] d,
                      output logic wr_n, output logic [15:0] ea, output logic ale_s);
      @(negedge clk);
      x_addr = a; x_wdata = d; x_wr = 1'b1;
      #1 wr_n = ext_wr_n; ea = ext_addr; ale_s = ale;
      @(negedge clk);
      x_wr = 1'b0;
   endtask

   task automatic xrd(input logic [15:0] a, output logic [7:0] d, output logic rd_n);
      @(negedge clk);
      x_addr = a; x_rd = 1'b1;
      #1 rd_n = ext_rd_n;
      @(negedge clk);
      x_rd = 1'b0;
      d = x_rdata;
   endtask

   task automatic power_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_reset_state();
      logic [7:0] d;
      sfr_read(8'hBF, d);
      chk("R1 ctrl reset value", d, 8'h02);
      chk("R1 isp_en reset", isp_en, 1'b0);
   endtask

   task automatic t_ctrl_reg();
      logic [7:0] d;
      sfr_write(8'hBF, 8'hFF);
      sfr_read(8'hBF, d);
      chk("R6 reserved bits read zero", d, 8'h87);
      chk("R5 isp_en follows bit 2", isp_en, 1'b1);
      sfr_write(8'hBE, 8'h00);
      sfr_read(8'hBF, d);
      chk("R5 other address ignored", d, 8'h87);
      sfr_read(8'hBE, d);
      chk("R5 other address reads zero", d, 8'h00);
      sfr_write(8'hBF, 8'h02);
      sfr_read(8'hBF, d);
      chk("R5 ctrl written back", d, 8'h02);
   endtask

   task automatic t_int_ram();
      logic wn, rn, a_s; logic [15:0] ea; logic [7:0] d;
      xwr(16'h0000, 8'h11, wn, ea, a_s);
      chk("R2 internal write no strobe 0x0000", wn, 1'b1);
      xwr(16'h02FF, 8'hA5, wn, ea, a_s);
      chk("R2 internal write no strobe 0x02FF", wn, 1'b1);
      xwr(16'h0155, 8'h3C, wn, ea, a_s);
      xrd(16'h0000, d, rn);
      chk("R2 read 0x0000", d, 8'h11);
      chk("R2 internal read no strobe", rn, 1'b1);
      xrd(16'h02FF, d, rn);
      chk("R2 read 0x02FF", d, 8'hA5);
      xrd(16'h0155, d, rn);
      chk("R2 read 0x0155", d, 8'h3C);
   endtask

   task automatic t_ext_route();
      logic wn, rn, a_s; logic [15:0] ea; logic [7:0] d;
      xwr(16'h0300, 8'h77, wn, ea, a_s);
      chk("R3 write 0x0300 strobe", wn, 1'b0);
      chk("R3 ext_addr 0x0300", ea, 16'h0300);
      xrd(16'h0000, d, rn);
      chk("R3 internal untouched", d, 8'h11);
      xrd(16'h0300, d, rn);
      chk("R3 read 0x0300 strobe", rn, 1'b0);
      chk("R10 ext read data 0x0300", d, 8'h5A);
      xrd(16'hFFFF, d, rn);
      chk("R10 ext read data 0xFFFF", d, 8'hA5);
      xrd(16'h02FF, d, rn);
      chk("R10 source returns to internal", d, 8'hA5);
   endtask

   task automatic t_ram_off();
      logic wn, rn, a_s; logic [15:0] ea; logic [7:0] d;
      sfr_write(8'hBF, 8'h00);
      xwr(16'h0000, 8'hEE, wn, ea, a_s);
      chk("R4 disabled write goes external", wn, 1'b0);
      xrd(16'h0000, d, rn);
      chk("R4 disabled read strobe", rn, 1'b0);
      chk("R4 disabled read data external", d, 8'h5A);
      sfr_write(8'hBF, 8'h02);
      xrd(16'h0000, d, rn);
      chk("R4 contents kept after re-enable", d, 8'h11);
   endtask

   task automatic t_ale();
      int n;
      logic wn, a_s; logic [15:0] ea;
      n = 0;
      for (int i = 0; i < 60; i++) begin
         @(negedge clk); #1 if (ale) n++;
      end
      chk("R7 ale pulses in 60 cycles", n, 10);
      sfr_write(8'hBF, 8'h03);
      n = 0;
      for (int i = 0; i < 60; i++) begin
         @(negedge clk); #1 if (ale) n++;
      end
      chk("R8 inhibited idle ale", n, 0);
      xwr(16'h1234, 8'h00, wn, ea, a_s);
      chk("R8 ale during external access", a_s, 1'b1);
      sfr_write(8'hBF, 8'h02);
   endtask

   task automatic t_wdt();
      logic [7:0] d;
      sfr_write(8'hBF, 8'h07);
      @(negedge clk); wdt_rst = 1'b1;
      @(negedge clk); wdt_rst = 1'b0;
      sfr_read(8'hBF, d);
      chk("R9 watchdog sets flag, restores bits", d, 8'h82);
      @(negedge clk); wdt_rst = 1'b1;
      @(negedge clk); wdt_rst = 1'b0;
      sfr_read(8'hBF, d);
      chk("R9 flag survives second watchdog reset", d, 8'h82);
      sfr_write(8'hBF, 8'h02);
      sfr_read(8'hBF, d);
      chk("R9 software clears flag", d, 8'h02);
      @(negedge clk); wdt_rst = 1'b1;
      @(negedge clk); wdt_rst = 1'b0;
      power_reset();
      sfr_read(8'hBF, d);
      chk("R9 power-on reset clears flag", d, 8'h02);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: run did not finish");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset_state();
      t_ctrl_reg();
      t_int_ram();
      t_ext_route();
      t_ram_off();
      power_reset();
      t_ale();
      t_wdt();
      summary();
      $finish;
   end
endmodule